// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes 64-bit command frames from a three-wire serial link made of a bit clock, a data line and a frame strobe. It checks each frame and loads the decoded fields into shadow registers, which the motor timing logic reads. Data is shifted in least-significant bit first, one bit on each rising edge of the serial clock while the strobe is high. The falling edge of the strobe closes the frame. The bits in byte 1 at positions 7:5 mark the frame as an initialization frame (111) or a run-time frame (000). Byte 8 is a checksum chosen so that the eight bytes add to zero modulo 256.

A good frame is written into its register set, either the initialization set or the per-channel run-time set. It also updates four open-drain monitor controls and raises the checksum status flag. The block announces the commit with a single-cycle `frame_valid` pulse that carries the frame type. The commit is a plain event with no back-pressure: there is no ready input, and the shadow registers hold the committed values until the next good frame replaces them. If the checksum fails, nothing is committed and the status flag goes low, which inhibits stepping downstream. If the frame has an illegal header or a wrong length, it is dropped silently.

All three serial inputs pass through the same synchronizer into the system clock domain, so the data bit stays aligned with its clock edge.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, `frame_valid` is 0, `csum_ok` is 1, `mon_sink` is 0000 (all pins released) and every shadow register is zero.
- R2: Run-time frame fields for channel c (c = 0, 1) come from these bytes. Byte 2+3c gives direction at bit 7, enable at bit 6 and a pulse count at bits 5:0. Byte 3+3c is the low 8 bits of the 15-bit step period. Bits 6:0 of byte 4+3c are the high 7 period bits, and bit 7 of that byte is the current-set select. Channel c occupies slice c of each output vector.
- R3: Initialization frame fields come from these bytes. Byte 2 is the start wait count and byte 3 is the drive wait count. Byte 4 gives the chopping source select at bit 7 and the chopping code at bits 4:0. Byte 5 bits 6:0 select the monitor signals. Byte 6+c holds channel c's first current code in bits 3:0 and its second current code in bits 7:4.
- R4: Header 111 commits as initialization (`frame_is_init`=1) and header 000 commits as run-time (`frame_is_init`=0). Each commit gives exactly one `frame_valid` pulse of one clock. Any other header code commits nothing.
- R5: A frame is accepted only if exactly 64 bits were clocked in while the strobe was high. With 63 or 65 bits, nothing is committed.
- R6: A frame of legal length and header whose byte sum is not 00h commits nothing and drives `csum_ok` low when the strobe falls. The next good frame brings `csum_ok` back high.
- R7: Serial clock edges while the strobe is low shift nothing and do not count toward the frame length.
- R8: A good frame of either type sets `mon_sink[i]` to the inverse of byte 1 bit i (0 sinks the pin, 1 releases it). Byte 1 bit 4 does not affect acceptance.
- R9: An initialization commit leaves the run-time registers unchanged, and a run-time commit leaves the initialization registers unchanged.
- R10: A frame dropped for its header or its length leaves `csum_ok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock, data sampled on rising edge |
| sdata | input | 1 | Serial data, LSB first |
| latch | input | 1 | Frame strobe, high during a frame, falling edge ends it |
| frame_valid | output | 1 | One-cycle pulse on a committed frame |
| frame_is_init | output | 1 | Type of last committed frame, 1 = initialization |
| csum_ok | output | 1 | Checksum status, low after a bad-sum frame |
| mon_sink | output | 4 | Open-drain monitor controls, 1 = pull pin low |
| start_wait | output | 8 | Start wait count |
| drive_wait | output | 8 | Drive wait count |
| chop_int | output | 1 | Chopping source select |
| chop_code | output | 5 | Chopping frequency code |
| mon_sel | output | 7 | Monitor signal selection |
| cur_code_a | output | 8 | First current code, 4 bits per channel |
| cur_code_b | output | 8 | Second current code, 4 bits per channel |
| run_dir | output | 2 | Direction per channel |
| run_en | output | 2 | Output enable per channel |
| run_pulses | output | 12 | 6-bit pulse count per channel |
| run_period | output | 30 | 15-bit step period per channel |
| run_cur_sel | output | 2 | Current-set select per channel |

## Verification
Bad internal state shows up at the ports at a single moment: the falling edge of the strobe. A bit counter that drifts makes a good frame vanish, so the bench sees no `frame_valid` pulse and the old shadow values remain. A misordered shift register puts field bits in the wrong place, and the check made a few clocks after the commit shows this as wrong register values. An accumulation error in the checksum either drops `csum_ok` on a good frame or lets a corrupted frame through. Either way it is visible within the same frame's commit window, so every frame is checked against a bench model before the next frame starts.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
  localparam int BYTE_W     = 8;
  localparam int N_BYTES    = 8;
  localparam int FRAME_BITS = BYTE_W * N_BYTES;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int N_CH       = 2;
  localparam int PULSE_W    = 6;
  localparam int PERIOD_W   = 15;
  localparam int CUR_W      = 4;
  localparam int MON_W      = 4;

  typedef enum logic [2:0] {
    HDR_RUN  = 3'b000,
    HDR_INIT = 3'b111
  } hdr_e;

  function automatic logic [BYTE_W-1:0] frame_byte(input logic [FRAME_BITS-1:0] f,
                                                   input int idx);
    return f[idx*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/cfr_sync.sv
module cfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfr_shifter.sv
module cfr_shifter
  import cmd_frame_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      nbits
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(FRAME_BITS + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      nbits <= '0;
    end else if (clr) begin
      nbits <= '0;
    end else if (bit_stb) begin
      frame <= {bit_val, frame[FRAME_BITS-1:1]};
      if (nbits != SAT) nbits <= nbits + 1'b1;
    end
  end
endmodule

// File: rtl/cfr_check.sv
module cfr_check
  import cmd_frame_pkg::*;
(
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [CNT_W-1:0]      nbits,
  output logic                  len_ok,
  output logic                  hdr_init,
  output logic                  hdr_run,
  output logic                  sum_ok
);
  logic [BYTE_W-1:0] acc;
  logic [2:0]        hdr;

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_BYTES; k++) acc = acc + frame_byte(frame, k);
  end

  assign hdr      = frame[7:5];
  assign len_ok   = (nbits == CNT_W'(FRAME_BITS));
  assign hdr_init = (hdr == HDR_INIT);
  assign hdr_run  = (hdr == HDR_RUN);
  assign sum_ok   = (acc == '0);
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       sdata,
  input  logic                       latch,
  output logic                       frame_valid,
  output logic                       frame_is_init,
  output logic                       csum_ok,
  output logic [MON_W-1:0]           mon_sink,
  output logic [7:0]                 start_wait,
  output logic [7:0]                 drive_wait,
  output logic                       chop_int,
  output logic [4:0]                 chop_code,
  output logic [6:0]                 mon_sel,
  output logic [N_CH*CUR_W-1:0]      cur_code_a,
  output logic [N_CH*CUR_W-1:0]      cur_code_b,
  output logic [N_CH-1:0]            run_dir,
  output logic [N_CH-1:0]            run_en,
  output logic [N_CH*PULSE_W-1:0]    run_pulses,
  output logic [N_CH*PERIOD_W-1:0]   run_period,
  output logic [N_CH-1:0]            run_cur_sel
);
  logic [2:0] s_in;
  logic       s_sclk, s_sdata, s_latch;
  logic       sclk_q, latch_q;
  logic       bit_stb, latch_rise, latch_fall;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      nbits;
  logic len_ok, hdr_init, hdr_run, sum_ok;
  logic legal, commit_init, commit_run;

  cfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({latch, sdata, sclk}), .q(s_in)
  );
  assign {s_latch, s_sdata, s_sclk} = s_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sclk_q  <= s_sclk;
      latch_q <= s_latch;
    end
  end

  assign bit_stb    = s_sclk & ~sclk_q & s_latch;
  assign latch_rise = s_latch & ~latch_q;
  assign latch_fall = ~s_latch & latch_q;

  cfr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(latch_rise), .bit_stb(bit_stb),
    .bit_val(s_sdata), .frame(frame), .nbits(nbits)
  );

  cfr_check u_check (
    .frame(frame), .nbits(nbits), .len_ok(len_ok),
    .hdr_init(hdr_init), .hdr_run(hdr_run), .sum_ok(sum_ok)
  );

  assign legal       = latch_fall & len_ok & (hdr_init | hdr_run);
  assign commit_init = legal & sum_ok & hdr_init;
  assign commit_run  = legal & sum_ok & hdr_run;

  // common status: commit pulse, type, checksum flag, monitor pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid   <= 1'b0;
      frame_is_init <= 1'b0;
      csum_ok       <= 1'b1;
      mon_sink      <= '0;
    end else begin
      frame_valid <= commit_init | commit_run;
      if (legal) csum_ok <= sum_ok;
      if (commit_init | commit_run) begin
        frame_is_init <= hdr_init;
        mon_sink      <= ~frame[MON_W-1:0];
      end
    end
  end

  // initialization register set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_wait <= '0;
      drive_wait <= '0;
      chop_int   <= 1'b0;
      chop_code  <= '0;
      mon_sel    <= '0;
    end else if (commit_init) begin
      start_wait <= frame_byte(frame, 1);
      drive_wait <= frame_byte(frame, 2);
      chop_int   <= frame[3*BYTE_W + 7];
      chop_code  <= frame[3*BYTE_W +: 5];
      mon_sel    <= frame[4*BYTE_W +: 7];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int CUR_BYTE = 5 + c;
    localparam int CTL_BYTE = 1 + 3*c;
    localparam int PLO_BYTE = 2 + 3*c;
    localparam int PHI_BYTE = 3 + 3*c;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_code_a[c*CUR_W +: CUR_W] <= '0;
        cur_code_b[c*CUR_W +: CUR_W] <= '0;
      end else if (commit_init) begin
        cur_code_a[c*CUR_W +: CUR_W] <= frame[CUR_BYTE*BYTE_W +: CUR_W];
        cur_code_b[c*CUR_W +: CUR_W] <= frame[CUR_BYTE*BYTE_W + CUR_W +: CUR_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_dir[c]                          <= 1'b0;
        run_en[c]                           <= 1'b0;
        run_pulses[c*PULSE_W +: PULSE_W]    <= '0;
        run_period[c*PERIOD_W +: PERIOD_W]  <= '0;
        run_cur_sel[c]                      <= 1'b0;
      end else if (commit_run) begin
        run_dir[c]                          <= frame[CTL_BYTE*BYTE_W + 7];
        run_en[c]                           <= frame[CTL_BYTE*BYTE_W + 6];
        run_pulses[c*PULSE_W +: PULSE_W]    <= frame[CTL_BYTE*BYTE_W +: PULSE_W];
        run_period[c*PERIOD_W +: PERIOD_W]  <= {frame[PHI_BYTE*BYTE_W +: 7],
                                                frame[PLO_BYTE*BYTE_W +: BYTE_W]};
        run_cur_sel[c]                      <= frame[PHI_BYTE*BYTE_W + 7];
      end
    end
  end
endmodule

// File: rtl/cmd_frame_rx_checker.sv
module cmd_frame_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic        frame_is_init,
  input logic        csum_ok,
  input logic [3:0]  mon_sink,
  input logic [7:0]  start_wait,
  input logic [4:0]  chop_code,
  input logic [7:0]  cur_code_a,
  input logic [11:0] run_pulses,
  input logic [29:0] run_period,
  input logic [1:0]  run_en
);
  // R4: commit pulse lasts a single clock
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R6: checksum flag returns high only with a commit
  p_csum_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csum_ok) |-> frame_valid);

  // R6: checksum flag drops only without a commit
  p_csum_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csum_ok) |-> !frame_valid);

  // R8: monitor pins move only on a commit
  p_mon_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mon_sink) |-> frame_valid);

  // R2: run registers move only on a run-time commit
  p_run_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(run_period) && $stable(run_pulses) && $stable(run_en))
      |-> (frame_valid && !frame_is_init));

  // R3: init registers move only on an init commit
  p_init_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(start_wait) && $stable(chop_code) && $stable(cur_code_a))
      |-> (frame_valid && frame_is_init));
endmodule

bind cmd_frame_rx cmd_frame_rx_checker u_cmd_frame_rx_checker (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
  .frame_is_init(frame_is_init), .csum_ok(csum_ok), .mon_sink(mon_sink),
  .start_wait(start_wait), .chop_code(chop_code), .cur_code_a(cur_code_a),
  .run_pulses(run_pulses), .run_period(run_period), .run_en(run_en)
);

// File: tb/cmd_frame_rx_bench.sv
module cmd_frame_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0;

  logic        frame_valid, frame_is_init, csum_ok, chop_int;
  logic [3:0]  mon_sink;
  logic [7:0]  start_wait, drive_wait, cur_code_a, cur_code_b;
  logic [4:0]  chop_code;
  logic [6:0]  mon_sel;
  logic [1:0]  run_dir, run_en, run_cur_sel;
  logic [11:0] run_pulses;
  logic [29:0] run_period;

  always #2 clk = ~clk;

  cmd_frame_rx u_cmd_frame_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .latch(latch),
    .frame_valid(frame_valid), .frame_is_init(frame_is_init), .csum_ok(csum_ok),
    .mon_sink(mon_sink), .start_wait(start_wait), .drive_wait(drive_wait),
    .chop_int(chop_int), .chop_code(chop_code), .mon_sel(mon_sel),
    .cur_code_a(cur_code_a), .cur_code_b(cur_code_b), .run_dir(run_dir),
    .run_en(run_en), .run_pulses(run_pulses), .run_period(run_period),
    .run_cur_sel(run_cur_sel)
  );

  int n_chk = 0, n_bad = 0;
  int pulses_seen = 0;
  logic last_type = 1'b0;
  bit done = 0;

  always @(negedge clk) if (frame_valid) begin
    pulses_seen++;
    last_type = frame_is_init;
  end

  // expected state
  int   e_pulses = 0;
  logic e_type = 0, e_csum = 1, e_chint = 0;
  logic [3:0]  e_mon = 0;
  logic [7:0]  e_sw = 0, e_dw = 0, e_ca = 0, e_cb = 0;
  logic [4:0]  e_cc = 0;
  logic [6:0]  e_ms = 0;
  logic [1:0]  e_dir = 0, e_en = 0, e_cs = 0;
  logic [11:0] e_pc = 0;
  logic [29:0] e_per = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bsum(input logic [63:0] w);
    logic [7:0] s = 0;
    for (int k = 0; k < 8; k++) s = s + w[k*8 +: 8];
    return s;
  endfunction

  function automatic logic [63:0] seal(input logic [55:0] body);
    logic [7:0] s = bsum({8'h00, body});
    return {8'(8'h00 - s), body};
  endfunction

  task automatic model(input logic [63:0] w, input int nb);
    logic [2:0] h = w[7:5];
    if (nb == 64 && (h == 3'b111 || h == 3'b000)) begin
      if (bsum(w) == 8'h00) begin
        e_pulses++;
        e_csum = 1;
        e_type = (h == 3'b111);
        e_mon  = ~w[3:0];
        if (e_type) begin
          e_sw = w[15:8]; e_dw = w[23:16];
          e_chint = w[31]; e_cc = w[28:24]; e_ms = w[38:32];
          e_ca = {w[51:48], w[43:40]};
          e_cb = {w[55:52], w[47:44]};
        end else begin
          e_dir = {w[39], w[15]};
          e_en  = {w[38], w[14]};
          e_pc  = {w[37:32], w[13:8]};
          e_per = {w[54:48], w[47:40], w[30:24], w[23:16]};
          e_cs  = {w[55], w[31]};
        end
      end else e_csum = 0;
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] w, input int nb);
    latch = 1'b1; wclk(6);
    for (int i = 0; i < nb; i++) begin
      sdata = (i < 64) ? w[i] : 1'b0;
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(4); latch = 1'b0; wclk(10);
    model(w, nb);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 pulse count"}, 64'(pulses_seen), 64'(e_pulses));
    if (e_pulses > 0) chk({tag, " R4 type"}, 64'(last_type), 64'(e_type));
    chk({tag, " R6 csum_ok"}, 64'(csum_ok), 64'(e_csum));
    chk({tag, " R8 mon_sink"}, 64'(mon_sink), 64'(e_mon));
    chk({tag, " R3 init regs"}, {27'd0, e_sw, e_dw, e_chint, e_cc, e_ms} ^
        {27'd0, start_wait, drive_wait, chop_int, chop_code, mon_sel}, 64'd0);
    chk({tag, " R3 current codes"}, {cur_code_b, cur_code_a}, {e_cb, e_ca});
    chk({tag, " R2 run ctl"}, {run_dir, run_en, run_cur_sel, run_pulses},
        {e_dir, e_en, e_cs, e_pc});
    chk({tag, " R2 run period"}, 64'(run_period), 64'(e_per));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'd2024));
    wclk(5);
    // R1: reset state
    chk("R1 frame_valid", 64'(frame_valid), 64'd0);
    chk("R1 csum_ok", 64'(csum_ok), 64'd1);
    chk("R1 mon_sink", 64'(mon_sink), 64'd0);
    chk("R1 shadows", {run_period, run_pulses, cur_code_a, start_wait} |
        {52'd0, cur_code_b, drive_wait}, 64'd0);
    rst_n = 1'b1; wclk(4);

    // R2: directed run-time frame
    send(seal({8'h7F, 8'hFF, 8'h3F, 8'h92, 8'h34, 8'hC5, 8'h05}), 64);
    check_all("run directed");
    chk("R2 ch0 period", 64'(run_period[14:0]), 64'h1234);
    chk("R2 ch1 pulses", 64'(run_pulses[11:6]), 64'd63);

    // R3/R9: directed init frame, run regs kept
    send(seal({8'hA5, 8'h3C, 8'h55, 8'h9F, 8'h40, 8'h81, 8'hE9}), 64);
    check_all("init directed R9");
    chk("R9 run kept", 64'(run_period[14:0]), 64'h1234);
    chk("R3 chop code", 64'(chop_code), 64'h1F);

    // R4: illegal header discarded
    send(seal({8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h4A}), 64);
    check_all("bad header R4");

    // R5: 63 and 65 bits discarded
    send(seal({8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0F}), 63);
    check_all("63 bits R5");
    send(seal({8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0F}), 65);
    check_all("65 bits R5");

    // R6: bad checksum, then R10: discarded frame keeps flag low
    w = seal({8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h03});
    w[63:56] = w[63:56] + 8'h01;
    send(w, 64);
    check_all("bad sum R6");
    send(seal({8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h83}), 64);
    check_all("bad header after bad sum R10");
    send(seal({8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h0A}), 64);
    check_all("good after bad R6");

    // R7: clock edges with strobe low, then a frame
    sdata = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    send(seal({8'h01, 8'h80, 8'h07, 8'h00, 8'h80, 8'h41, 8'h06}), 64);
    check_all("idle clocks R7");

    // R8: byte1 bit4 set still accepted
    send(seal({8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h1C}), 64);
    check_all("bit4 set R8");

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [55:0] body;
      int nb;
      body = {$urandom(), $urandom()};
      case ($urandom_range(0, 9))
        0:       body[7:5] = 3'($urandom_range(1, 6));
        1, 2, 3: body[7:5] = 3'b111;
        default: body[7:5] = 3'b000;
      endcase
      w = seal(body);
      if ($urandom_range(0, 7) == 0) w[63:56] = w[63:56] ^ 8'h10;
      nb = ($urandom_range(0, 11) == 0) ? 62 + $urandom_range(0, 4) : 64;
      send(w, nb);
      check_all("random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule